// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Reset

This block guards a clock-frequency change made while the system is running. Software first picks a timeout from a 4-bit field, in steps of two seconds, and then changes the frequency. That change arms a countdown. Software may confirm that the system survived the change by writing zero to the timeout field. If it does so before the count runs out, the new frequency stays in effect.

If no confirmation arrives in time, the block does three things in the same cycle. It raises a sticky alarm flag, it drives an active-low system reset for a fixed number of cycles, and it issues a one-cycle revert command. That command carries a source select, which chooses between the strap-latched frequency setting and the last setting written by software.

All inputs are plain register-field levels or single-cycle event strobes, and all outputs are plain control and status pins. Time is measured with a one-second tick whose length is a parameter in reference-clock cycles. The reset-pulse length is also a parameter, so both can be scaled down for simulation.

Top module: `wdg_freq_guard`

## Requirements
- R1: After reset, `alarm` is 0, `sys_rst_n` is 1 and `revert_req` is 0.
- R2: When `freq_chg` is sampled high and `tmo_sel` = N is nonzero (N from 1 to 15), the timer arms. Expiry then falls exactly 2·N·TICK_CYC cycles after the edge that sampled the event, including the largest setting N = 15.
- R3: When `freq_chg` is sampled high while `tmo_sel` is 0, the timer does not arm, and no alarm, reset or revert follows.
- R4: When `tmo_sel` is sampled as 0 while the timer runs, the count is cancelled, and no alarm, reset or revert follows.
- R5: At expiry, `alarm` becomes 1 in the same cycle that `sys_rst_n` goes low and `revert_req` is high. `alarm` then stays 1 until R8 clears it.
- R6: `sys_rst_n` stays low for exactly RST_CYC consecutive cycles after expiry.
- R7: A 0-to-1 edge on `reload` while the timer runs restarts the full count from the current `tmo_sel`. Holding `reload` high has no further effect. A rising edge while the timer is idle is ignored.
- R8: `alarm` reads 0 in the cycle after `tmo_sel` is sampled as 0.
- R9: `revert_req` is a single-cycle pulse. In that cycle `revert_src` equals `recover_sw` as sampled at expiry, where 0 selects the strap-latched setting and 1 selects the last software setting.
- R10: When a different nonzero value is sampled on `tmo_sel` while the timer runs, the count restarts with the new period, measured from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_sel | input | SEL_W | Timeout field: 0 means off, N means N·STEP_SEC seconds |
| reload | input | 1 | Count-refresh bit; acts on its rising edge only |
| recover_sw | input | 1 | Revert target: 0 is strap setting, 1 is last software setting |
| freq_chg | input | 1 | One-cycle strobe on a software frequency-select write or on enabling programmable frequency |
| alarm | output | 1 | Sticky timeout flag |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| revert_req | output | 1 | One-cycle revert command |
| revert_src | output | 1 | Revert target latched at expiry |

## Verification
Every result is timed from the clock edge that samples the stimulus; call that edge E. An arm or restart at E expires at edge E + 2·N·TICK_CYC. At that edge `alarm`, `revert_req` and the falling `sys_rst_n` all appear together. The reset then stays low for RST_CYC cycles, and an alarm clear shows one edge after E.

The driver counts edges and pushes the exact expected expiry edge into a queue. A monitor samples on the falling clock edge, so it sees each output one half-cycle after the register that drives it. It compares every revert pulse against the head of the queue, and any pulse that arrives with the queue empty counts as a failure.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic {
    REVERT_STRAP = 1'b0,
    REVERT_SOFT  = 1'b1
  } revert_src_e;
endpackage

// File: rtl/wdg_sec_tick.sv
module wdg_sec_tick #(
  parameter int TICK_CYC = 14318180
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int CW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == CW'(TICK_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else if (en)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int SEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  input  logic             stop,
  input  logic             tick,
  output logic             running,
  output logic             expire
);
  logic [SEC_W-1:0] left_q;

  // Cancel and restart both outrank expiry in the same cycle.
  assign expire = running && tick && (left_q == SEC_W'(1)) && !stop && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      left_q  <= '0;
    end else if (stop) begin
      running <= 1'b0;
    end else if (load) begin
      running <= 1'b1;
      left_q  <= load_val;
    end else if (expire) begin
      running <= 1'b0;
    end else if (running && tick) begin
      left_q  <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdg_pulse_stretch.sv
module wdg_pulse_stretch #(
  parameter int RST_CYC = 42955
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic out_n
);
  localparam int PW = $clog2(RST_CYC + 1);

  logic [PW-1:0] cnt_q;

  assign out_n = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (fire)           cnt_q <= PW'(RST_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdg_freq_guard.sv
module wdg_freq_guard
  import wdg_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int STEP_SEC = 2,
  parameter int TICK_CYC = 14318180,
  parameter int RST_CYC  = 42955
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] tmo_sel,
  input  logic             reload,
  input  logic             recover_sw,
  input  logic             freq_chg,
  output logic             alarm,
  output logic             sys_rst_n,
  output logic             revert_req,
  output logic             revert_src
);
  localparam int MAX_SEC = ((1 << SEL_W) - 1) * STEP_SEC;
  localparam int SEC_W   = $clog2(MAX_SEC + 1);

  logic [SEL_W-1:0] tmo_q;
  logic             rld_q;
  logic             tmo_zero, rld_rise, tmo_new, arm;
  logic             running, tick, expire;
  logic [SEC_W-1:0] load_val;
  revert_src_e      src_q;

  assign tmo_zero = (tmo_sel == '0);
  assign rld_rise = reload && !rld_q;
  assign tmo_new  = (tmo_sel != tmo_q);
  assign arm      = !tmo_zero && (freq_chg || (running && (rld_rise || tmo_new)));
  assign load_val = SEC_W'(int'(tmo_sel) * STEP_SEC);

  wdg_sec_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (arm),
    .en    (running),
    .tick  (tick)
  );

  wdg_countdown #(.SEC_W(SEC_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (arm),
    .load_val (load_val),
    .stop     (tmo_zero),
    .tick     (tick),
    .running  (running),
    .expire   (expire)
  );

  wdg_pulse_stretch #(.RST_CYC(RST_CYC)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (expire),
    .out_n (sys_rst_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q      <= '0;
      rld_q      <= 1'b0;
      alarm      <= 1'b0;
      revert_req <= 1'b0;
      src_q      <= REVERT_STRAP;
    end else begin
      tmo_q      <= tmo_sel;
      rld_q      <= reload;
      revert_req <= expire;
      if (tmo_zero)    alarm <= 1'b0;
      else if (expire) alarm <= 1'b1;
      if (expire)      src_q <= revert_src_e'(recover_sw);
    end
  end

  assign revert_src = src_q;
endmodule

// File: rtl/wdg_freq_guard_chk.sv
module wdg_freq_guard_chk #(
  parameter int SEL_W   = 4,
  parameter int RST_CYC = 42955
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] tmo_sel,
  input logic             recover_sw,
  input logic             alarm,
  input logic             sys_rst_n,
  input logic             revert_req,
  input logic             revert_src
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= '0;
    else if (!sys_rst_n) low_cnt <= low_cnt + 1;
    else                 low_cnt <= '0;
  end

  p_reset_with_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_n) |-> (alarm && revert_req));

  p_pulse_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> (low_cnt == 32'(RST_CYC)));

  p_alarm_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_sel == '0) |=> !alarm);

  p_zero_field_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_sel == '0) |=> !revert_req);

  p_revert_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    revert_req |=> !revert_req);

  p_revert_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    revert_req |-> (revert_src == $past(recover_sw)));
endmodule

bind wdg_freq_guard wdg_freq_guard_chk #(.SEL_W(SEL_W), .RST_CYC(RST_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tmo_sel    (tmo_sel),
  .recover_sw (recover_sw),
  .alarm      (alarm),
  .sys_rst_n  (sys_rst_n),
  .revert_req (revert_req),
  .revert_src (revert_src)
);

// File: tb/wdg_freq_guard_tb.sv
`timescale 1ns/1ps
module wdg_freq_guard_tb;
  localparam int TICK  = 10;
  localparam int RSTC  = 5;
  localparam int LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tmo_sel = '0;
  logic       reload = 1'b0;
  logic       recover_sw = 1'b0;
  logic       freq_chg = 1'b0;
  logic       alarm, sys_rst_n, revert_req, revert_src;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int low_run = 0;
  bit done = 1'b0;

  int    exp_cyc[$];
  bit    exp_src[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdg_freq_guard #(.SEL_W(4), .STEP_SEC(2), .TICK_CYC(TICK), .RST_CYC(RSTC)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmo_sel(tmo_sel), .reload(reload),
    .recover_sw(recover_sw), .freq_chg(freq_chg), .alarm(alarm),
    .sys_rst_n(sys_rst_n), .revert_req(revert_req), .revert_src(revert_src)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Expiry due 2*N*TICK edges after the sampling edge (cyc+1).
  task automatic push_exp(int n, bit src, string tag);
    exp_cyc.push_back(cyc + 1 + 2 * n * TICK);
    exp_src.push_back(src);
    exp_tag.push_back(tag);
  endtask

  task automatic fire_chg();
    freq_chg = 1'b1;
    step(1);
    freq_chg = 1'b0;
  endtask

  task automatic clear_and_check();
    check(alarm == 1'b1, "R5 alarm sticky before clear", alarm, 1);
    tmo_sel = '0;
    step(1);
    @(negedge clk);
    check(alarm == 1'b0, "R8 alarm cleared", alarm, 0);
    step(2);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (revert_req) begin
        if (exp_cyc.size() == 0) begin
          check(1'b0, "R4 unexpected revert (R3/R10 arming)", cyc, -1);
        end else begin
          int ec; bit es; string et;
          ec = exp_cyc.pop_front();
          es = exp_src.pop_front();
          et = exp_tag.pop_front();
          check(cyc == ec, {et, " expiry cycle"}, cyc, ec);
          check(revert_src == es, "R9 revert source", revert_src, es);
          check(alarm == 1'b1, "R5 alarm at expiry", alarm, 1);
          check(sys_rst_n == 1'b0, "R5 reset low at expiry", sys_rst_n, 0);
        end
      end
      if (!sys_rst_n) low_run++;
      else if (low_run != 0) begin
        check(low_run == RSTC, "R6 reset pulse width", low_run, RSTC);
        low_run = 0;
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc == LIMIT && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    @(negedge clk);
    check(alarm == 1'b0,      "R1 alarm reset",  alarm, 0);
    check(sys_rst_n == 1'b1,  "R1 sys_rst_n reset", sys_rst_n, 1);
    check(revert_req == 1'b0, "R1 revert reset", revert_req, 0);
    step(1);
    rst_n = 1'b1;
    step(2);

    // R3: change with field off
    fire_chg();
    step(100);
    @(negedge clk);
    check(alarm == 1'b0 && sys_rst_n == 1'b1, "R3 no arm with zero field", alarm, 0);

    // R2, R9 strap source, N=1
    tmo_sel = 4'd1; recover_sw = 1'b0;
    step(2);
    push_exp(1, 1'b0, "R2 N=1");
    fire_chg();
    step(40);
    clear_and_check();

    // R7 reload edge while running, soft source
    tmo_sel = 4'd2; recover_sw = 1'b1;
    step(2);
    fire_chg();
    step(15);
    reload = 1'b1;
    push_exp(2, 1'b1, "R7 reload restart");
    step(60);
    reload = 1'b0;
    clear_and_check();

    // R4 cancel
    tmo_sel = 4'd3;
    step(2);
    fire_chg();
    step(30);
    tmo_sel = '0;
    step(100);
    @(negedge clk);
    check(alarm == 1'b0 && sys_rst_n == 1'b1, "R4 cancel leaves no alarm", alarm, 0);
    step(1);

    // R10 new nonzero period while running
    tmo_sel = 4'd1; recover_sw = 1'b0;
    step(2);
    fire_chg();
    step(10);
    tmo_sel = 4'd2;
    push_exp(2, 1'b0, "R10 new period");
    step(60);
    clear_and_check();

    // R7 rising edge while idle ignored, held level no effect
    tmo_sel = 4'd1; recover_sw = 1'b1;
    reload = 1'b1;
    step(3);
    push_exp(1, 1'b1, "R7 idle edge ignored");
    fire_chg();
    step(40);
    reload = 1'b0;
    clear_and_check();

    // R2 largest setting
    tmo_sel = 4'd15; recover_sw = 1'b0;
    step(2);
    push_exp(15, 1'b0, "R2 N=15");
    fire_chg();
    step(320);
    clear_and_check();

    step(10);
    check(exp_cyc.size() == 0, "R2 all expected expiries seen", exp_cyc.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule